// File: doc/BRIEF.md
# Multiplexed-Bus Memory and Register Front End

This block is the bus side of a peripheral that sits on a shared 8-bit address/data bus. While the address latch enable is high, the block samples the bus value together with the chip enable and the memory/IO select. When the latch enable falls, these values are frozen. The frozen select sends every later read or write strobe to one of two places: a 256-byte static memory, or a register file of eight I/O slots that only the low three address bits decode.

Slot zero works two ways. A write to it loads the command byte, which the rest of the peripheral uses, and that byte can never be read back. A read from it returns the status byte supplied by the port and timer logic. When such a read finishes, the block emits a one-cycle pulse that clears the timer flag. Slots one to five belong to the port and timer registers. Writes to them come out as one-hot strobes with the write data. Reads from them return data that the neighbouring logic supplies for the current register select. All strobes and bus pins are sampled on the system clock. A write commits when the write strobe rises, using the last data byte seen while the strobe was low.

Top module: `busFrontEnd`

## Requirements
- R1: While `ale` is high, the block takes the bus byte, `chipEn` and `ioSel` at every clock edge. After `ale` falls they are held, and later changes on those pins do not alter the target of the access or `regSel`. `regSel` carries the low three held address bits.
- R2: With the held select at 0, a write stores a byte in the 256x8 memory at the full held address, and a later read of that address returns it.
- R3: An I/O write whose held address has low bits 000 loads `cmdByte`, whatever the upper five bits are. `cmdLoad` is high for exactly the one cycle that follows the clock edge at which `wrN` is first seen high again.
- R4: An I/O read at low bits 000 drives {0, `statusIn[6:0]`} onto the bus and never the command byte.
- R5: `cmdByte` changes only in the cycle in which `cmdLoad` is high. Memory writes, other register writes and reads leave it unchanged.
- R6: An I/O write to slot k (001 to 101) pulses bit k-1 of `regWrStb` for one cycle and presents the written byte on `regWrData`. At most one write strobe, including `cmdLoad`, is high in any cycle.
- R7: An I/O read of slots 001 to 101 returns `regRdData`. Slots 110 and 111 read as 0x00.
- R8: `adOe` is high only while `rdN` is low and the held chip enable is 1. When `adOe` is low, `adOut` is 0x00.
- R9: An I/O read of slot 000 raises `timerFlagClr` for one cycle, after the clock edge at which `rdN` is first seen high again. Reads of any other slot or of memory give no pulse.
- R10: With the held chip enable at 0, a write changes neither memory, `cmdByte` nor any strobe.
- R11: The committed write byte is the last bus value sampled while `wrN` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ale | input | 1 | Address latch enable, active high |
| adIn | input | 8 | Multiplexed address/data bus, inbound |
| adOut | output | 8 | Read data driven onto the bus |
| adOe | output | 1 | Bus output enable |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| chipEn | input | 1 | Chip enable, active high, held by `ale` |
| ioSel | input | 1 | Space select, 1 for the register file and 0 for memory, held by `ale` |
| statusIn | input | 7 | Status bits returned at slot 000 (bit 6 is the timer flag) |
| regRdData | input | 8 | Read data for slots 001 to 101 |
| regSel | output | 3 | Held register slot for the read-data mux |
| cmdByte | output | 8 | Current command byte |
| cmdLoad | output | 1 | One-cycle pulse when the command byte is loaded |
| regWrStb | output | 5 | One-hot write strobes for slots 001 to 101 |
| regWrData | output | 8 | Byte of the most recent committed write |
| timerFlagClr | output | 1 | One-cycle clear pulse after a status read |

## Verification
Two events can fall in the same clock edge: a write committing on the rise of `wrN`, and `ale` capturing the address of the next access. Some bus cycles in the bench raise `wrN` and `ale` together, with a different address and select on the bus. The per-clock model then expects the commit to reach the old target, and the following access to use the new one. Directed checks read back memory and `cmdByte` after these overlapped cycles, and the per-cycle comparison of every output catches a strobe that went to the wrong target.

// File: rtl/busfe_pkg.sv
package busfe_pkg;

  // number of port/timer register slots behind the command/status slot
  localparam int PORT_REGS = 5;

  typedef struct packed {
    logic                 anyWe;     // a write commits this cycle
    logic                 ramWe;     // commit targets memory
    logic                 cmdWe;     // commit targets the command byte
    logic [PORT_REGS-1:0] regWe;     // commit targets a port/timer slot
    logic                 statClr;   // a status read has just finished
  } feStrobes_t;

endpackage

// File: rtl/busCtrl.sv
module busCtrl
  import busfe_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdN,
  input  logic             wrN,
  input  logic             ceQ,
  input  logic             ioQ,
  input  logic [SEL_W-1:0] selQ,
  output feStrobes_t       stb,
  output logic             adOe
);

  logic rdPrev;
  logic wrPrev;
  logic wrDone;
  logic rdDone;
  logic [PORT_REGS-1:0] regHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPrev <= 1'b1;
      wrPrev <= 1'b1;
    end else begin
      rdPrev <= rdN;
      wrPrev <= wrN;
    end
  end

  // strobe end: low at the previous edge, high now
  assign wrDone = !wrPrev && wrN && ceQ;
  assign rdDone = !rdPrev && rdN && ceQ;

  generate
    for (genvar k = 0; k < PORT_REGS; k++) begin : g_slot
      assign regHit[k] = (selQ == SEL_W'(k + 1));
    end
  endgenerate

  always_comb begin
    stb.anyWe   = wrDone;
    stb.ramWe   = wrDone && !ioQ;
    stb.cmdWe   = wrDone && ioQ && (selQ == '0);
    stb.regWe   = (wrDone && ioQ) ? regHit : '0;
    stb.statClr = rdDone && ioQ && (selQ == '0);
  end

  assign adOe = !rdN && ceQ;

  // R6
  ctrl_we_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.ramWe, stb.cmdWe, stb.regWe}));

endmodule

// File: rtl/busData.sv
module busData
  import busfe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int SEL_W  = 3,
  parameter int STAT_W = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ale,
  input  logic                 wrN,
  input  logic                 rdN,
  input  logic [DATA_W-1:0]    adIn,
  input  logic                 chipEn,
  input  logic                 ioSel,
  input  feStrobes_t           stb,
  input  logic                 adOe,
  input  logic [STAT_W-1:0]    statusIn,
  input  logic [DATA_W-1:0]    regRdData,
  output logic                 ceQ,
  output logic                 ioQ,
  output logic [SEL_W-1:0]     selQ,
  output logic [DATA_W-1:0]    adOut,
  output logic [DATA_W-1:0]    cmdByte,
  output logic                 cmdLoad,
  output logic [PORT_REGS-1:0] regWrStb,
  output logic [DATA_W-1:0]    regWrData,
  output logic                 timerFlagClr
);

  localparam int RAM_DEPTH = 1 << ADDR_W;
  localparam int PAD_W     = DATA_W - STAT_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wrBuf;
  logic [DATA_W-1:0] ram [RAM_DEPTH];
  logic [DATA_W-1:0] ramRd;
  logic [DATA_W-1:0] regRd;

  // address phase: follow the bus while ale is high, hold after it falls
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      ceQ   <= 1'b0;
      ioQ   <= 1'b0;
    end else if (ale) begin
      addrQ <= adIn[ADDR_W-1:0];
      ceQ   <= chipEn;
      ioQ   <= ioSel;
    end
  end

  assign selQ = addrQ[SEL_W-1:0];

  // data phase: keep the last byte seen while the write strobe is low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrBuf <= '0;
    else if (!wrN) wrBuf <= adIn;
  end

  always_ff @(posedge clk) begin
    if (stb.ramWe) ram[addrQ] <= wrBuf;
  end

  assign ramRd = ram[addrQ];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdByte      <= '0;
      cmdLoad      <= 1'b0;
      regWrStb     <= '0;
      regWrData    <= '0;
      timerFlagClr <= 1'b0;
    end else begin
      cmdLoad      <= stb.cmdWe;
      regWrStb     <= stb.regWe;
      timerFlagClr <= stb.statClr;
      if (stb.cmdWe) cmdByte   <= wrBuf;
      if (stb.anyWe) regWrData <= wrBuf;
    end
  end

  // register-file read mux; slot 0 on reads is status, never the command
  always_comb begin
    regRd = '0;
    if (selQ == '0)
      regRd = {{PAD_W{1'b0}}, statusIn};
    else if (selQ <= SEL_W'(PORT_REGS))
      regRd = regRdData;
  end

  assign adOut = adOe ? (ioQ ? regRd : ramRd) : '0;

  // R5
  cmd_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmdLoad |-> $stable(cmdByte));

  // R3
  cmd_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdLoad |-> ($past(wrN) && !$past(wrN, 2)));

  // R9
  clr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    timerFlagClr |=> !timerFlagClr);

  // R9
  clr_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    timerFlagClr |-> ($past(rdN) && !$past(rdN, 2)));

  // R6
  wr_strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdLoad, regWrStb}));

  // R8
  bus_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !adOe |-> (adOut == '0));

endmodule

// File: rtl/busFrontEnd.sv
module busFrontEnd
  import busfe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int SEL_W  = 3,
  parameter int STAT_W = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ale,
  input  logic [DATA_W-1:0]    adIn,
  output logic [DATA_W-1:0]    adOut,
  output logic                 adOe,
  input  logic                 rdN,
  input  logic                 wrN,
  input  logic                 chipEn,
  input  logic                 ioSel,
  input  logic [STAT_W-1:0]    statusIn,
  input  logic [DATA_W-1:0]    regRdData,
  output logic [SEL_W-1:0]     regSel,
  output logic [DATA_W-1:0]    cmdByte,
  output logic                 cmdLoad,
  output logic [PORT_REGS-1:0] regWrStb,
  output logic [DATA_W-1:0]    regWrData,
  output logic                 timerFlagClr
);

  feStrobes_t stb;
  logic       ceQ;
  logic       ioQ;
  logic [SEL_W-1:0] selQ;

  busCtrl #(.SEL_W(SEL_W)) uCtrl (
    .clk  (clk),
    .rstN (rstN),
    .rdN  (rdN),
    .wrN  (wrN),
    .ceQ  (ceQ),
    .ioQ  (ioQ),
    .selQ (selQ),
    .stb  (stb),
    .adOe (adOe)
  );

  busData #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .SEL_W  (SEL_W),
    .STAT_W (STAT_W)
  ) uData (
    .clk          (clk),
    .rstN         (rstN),
    .ale          (ale),
    .wrN          (wrN),
    .rdN          (rdN),
    .adIn         (adIn),
    .chipEn       (chipEn),
    .ioSel        (ioSel),
    .stb          (stb),
    .adOe         (adOe),
    .statusIn     (statusIn),
    .regRdData    (regRdData),
    .ceQ          (ceQ),
    .ioQ          (ioQ),
    .selQ         (selQ),
    .adOut        (adOut),
    .cmdByte      (cmdByte),
    .cmdLoad      (cmdLoad),
    .regWrStb     (regWrStb),
    .regWrData    (regWrData),
    .timerFlagClr (timerFlagClr)
  );

  assign regSel = selQ;

endmodule

// File: tb/busFrontEnd_test.sv
module busFrontEnd_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ale = 1'b0;
  logic [7:0] adIn = 8'h00;
  logic [7:0] adOut;
  logic       adOe;
  logic       rdN = 1'b1;
  logic       wrN = 1'b1;
  logic       chipEn = 1'b0;
  logic       ioSel = 1'b0;
  logic [6:0] statusIn = 7'h00;
  logic [7:0] regRdData;
  logic [2:0] regSel;
  logic [7:0] cmdByte;
  logic       cmdLoad;
  logic [4:0] regWrStb;
  logic [7:0] regWrData;
  logic       timerFlagClr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // neighbour read data depends only on the selected slot
  assign regRdData = {regSel, 5'h0} ^ 8'h96;

  busFrontEnd uut (
    .clk(clk), .rstN(rstN), .ale(ale), .adIn(adIn), .adOut(adOut), .adOe(adOe),
    .rdN(rdN), .wrN(wrN), .chipEn(chipEn), .ioSel(ioSel), .statusIn(statusIn),
    .regRdData(regRdData), .regSel(regSel), .cmdByte(cmdByte), .cmdLoad(cmdLoad),
    .regWrStb(regWrStb), .regWrData(regWrData), .timerFlagClr(timerFlagClr)
  );

  // ---------------- behavioural reference ----------------
  logic [7:0] mAddr, mWrBuf, mCmd, mRegData;
  logic       mCe, mIo, mWrPrev, mRdPrev, mCmdLoad, mClr;
  logic [4:0] mRegStb;
  logic [7:0] mRam [int];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mAddr = 0; mCe = 0; mIo = 0; mWrPrev = 1; mRdPrev = 1; mWrBuf = 0;
      mCmd = 0; mCmdLoad = 0; mRegStb = 0; mRegData = 0; mClr = 0;
    end else begin
      bit wrEnd, rdEnd;
      int slot;
      wrEnd = !mWrPrev && wrN && mCe;
      rdEnd = !mRdPrev && rdN && mCe;
      slot = mAddr % 8;
      mCmdLoad = wrEnd && mIo && slot == 0;
      mRegStb = 0;
      if (wrEnd && mIo && slot >= 1 && slot <= 5) mRegStb[slot-1] = 1'b1;
      if (wrEnd) mRegData = mWrBuf;
      if (mCmdLoad) mCmd = mWrBuf;
      if (wrEnd && !mIo) mRam[int'(mAddr)] = mWrBuf;
      mClr = rdEnd && mIo && slot == 0;
      if (!wrN) mWrBuf = adIn;
      mWrPrev = wrN;
      mRdPrev = rdN;
      if (ale) begin mAddr = adIn; mCe = chipEn; mIo = ioSel; end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    logic eOe;
    int slot;
    eOe = !rdN && mCe;
    slot = mAddr % 8;
    chk("R1 regSel", 32'(regSel), 32'(mAddr[2:0]));
    chk("R8 adOe", 32'(adOe), 32'(eOe));
    chk("R5 cmdByte", 32'(cmdByte), 32'(mCmd));
    chk("R3 cmdLoad", 32'(cmdLoad), 32'(mCmdLoad));
    chk("R6 regWrStb", 32'(regWrStb), 32'(mRegStb));
    chk("R11 regWrData", 32'(regWrData), 32'(mRegData));
    chk("R9 timerFlagClr", 32'(timerFlagClr), 32'(mClr));
    if (!eOe) chk("R8 adOut released", 32'(adOut), 0);
    else if (mIo) begin
      if (slot == 0) chk("R4 status read", 32'(adOut), 32'({1'b0, statusIn}));
      else if (slot <= 5) chk("R7 slot read", 32'(adOut), 32'({mAddr[2:0], 5'h0} ^ 8'h96));
      else chk("R7 unused slot", 32'(adOut), 0);
    end else if (mRam.exists(int'(mAddr)))
      chk("R2 memory read", 32'(adOut), 32'(mRam[int'(mAddr)]));
  endtask

  task automatic step();
    @(negedge clk);
    compareAll();
  endtask

  logic [7:0] lastRead;
  logic       lastOe;

  task automatic busCycle(input logic io, input logic ce, input logic [7:0] addr,
                          input logic isWr, input logic [7:0] data, input logic overlap);
    ale = 1; adIn = addr; chipEn = ce; ioSel = io; step();
    ale = 0; adIn = ~addr; chipEn = ~ce; ioSel = ~io; step();
    if (isWr) begin
      wrN = 0; adIn = data ^ 8'hFF; step();
      adIn = data; step();
      wrN = 1; adIn = 8'h3C;
      if (overlap) begin ale = 1; adIn = addr ^ 8'h09; chipEn = ce; ioSel = ~io; end
      step();
      ale = 0; step();
    end else begin
      rdN = 0; step(); step();
      lastRead = adOut; lastOe = adOe;
      rdN = 1; step(); step();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned lfsr;
    repeat (3) @(negedge clk);
    rstN = 1;
    step();
    chk("R5 reset cmdByte", 32'(cmdByte), 0);
    chk("R8 reset adOe", 32'(adOe), 0);

    // memory space
    busCycle(0, 1, 8'h00, 1, 8'h11, 0);
    busCycle(0, 1, 8'h37, 1, 8'hA7, 0);
    busCycle(0, 1, 8'hFF, 1, 8'h5E, 0);
    busCycle(0, 1, 8'h37, 0, 0, 0);
    chk("R2 read 0x37", 32'(lastRead), 32'h A7);
    busCycle(0, 1, 8'hFF, 0, 0, 0);
    chk("R2 read 0xFF", 32'(lastRead), 32'h5E);
    chk("R5 memory writes leave cmd", 32'(cmdByte), 0);

    // command writes, upper bits ignored
    busCycle(1, 1, 8'h00, 1, 8'h5C, 0);
    chk("R3 cmd at 0x00", 32'(cmdByte), 32'h5C);
    busCycle(1, 1, 8'hF8, 1, 8'hC3, 0);
    chk("R3 cmd at 0xF8", 32'(cmdByte), 32'hC3);

    // status reads
    statusIn = 7'h55;
    busCycle(1, 1, 8'h08, 0, 0, 0);
    chk("R4 status not cmd", 32'(lastRead), 32'h55);
    statusIn = 7'h2A;
    busCycle(1, 1, 8'h00, 0, 0, 0);
    chk("R4 status 0x2A", 32'(lastRead), 32'h2A);

    // port/timer slots
    for (int s = 1; s < 8; s++) busCycle(1, 1, 8'(s), 1, 8'(8'h40 + s), 0);
    chk("R6 slot writes leave cmd", 32'(cmdByte), 32'hC3);
    for (int s = 1; s < 8; s++) begin
      busCycle(1, 1, 8'(s | 8'h70), 0, 0, 0);
      chk("R7 slot read", 32'(lastRead), (s <= 5) ? 32'((8'(s) << 5) ^ 8'h96) : 0);
    end

    // chip not enabled
    busCycle(1, 0, 8'h00, 1, 8'h99, 0);
    chk("R10 disabled cmd write", 32'(cmdByte), 32'hC3);
    busCycle(0, 0, 8'h37, 1, 8'h99, 0);
    busCycle(0, 0, 8'h37, 0, 0, 0);
    chk("R8 disabled read no drive", 32'(lastOe), 0);
    busCycle(0, 1, 8'h37, 0, 0, 0);
    chk("R10 disabled memory write", 32'(lastRead), 32'hA7);

    // write end coinciding with next address capture
    busCycle(1, 1, 8'h00, 1, 8'h6D, 1);
    chk("R1 overlap cmd", 32'(cmdByte), 32'h6D);
    busCycle(0, 1, 8'h10, 1, 8'h77, 1);
    busCycle(0, 1, 8'h10, 0, 0, 0);
    chk("R1 overlap memory", 32'(lastRead), 32'h77);
    chk("R1 overlap no cmd", 32'(cmdByte), 32'h6D);

    // pseudo-random traffic against the model
    lfsr = 32'h1ACE5EED;
    for (int n = 0; n < 300; n++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      statusIn = 7'(lfsr >> 20);
      busCycle(lfsr[0], lfsr[1] | lfsr[2], 8'(lfsr >> 8), lfsr[3], 8'(lfsr >> 16), lfsr[4]);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule